// File: doc/BRIEF.md
# Oscillator Configuration Command Channel

This block is a command-driven configuration port that sits in a 32-bit APB-style register window. It holds a small bank of oscillator-frequency words. Software first places a data word in an outgoing register. It then writes a control word that carries a device index, a function code, a direction flag and a start flag. A control write with start set runs the transfer against the bank at once. A write copies the outgoing word into the chosen oscillator slot. A read copies the chosen slot into a return register. The outcome is posted in a status register, which software reads in its next transfer.

The bank is also presented as a flat registered bus, so downstream logic (for example a clock-generator shim) can follow the programmed values. The transfers use zero wait states. Writes commit in the access phase. Read data is registered in the setup phase and is valid in the access phase.

Top module: `osc_cfg_port`

## Requirements
- R1: Register offsets are: 0xA0 return data (read-only), 0xA4 outgoing data (read/write), 0xA8 control, 0xAC status (read-only). A read of any other offset returns zero.
- R2: The control register keeps the written value ANDed with 0x43F00FFF. This means device [11:0], function [25:20] and direction [30] are kept, while bits [19:12], [29:26] and start bit 31 always read back as zero.
- R3: Every control write clears the status register first. A control write with bit 31 clear leaves the status reading 0.
- R4: A control write with bit 31 set sets status bit 0 (done). A status read in the very next transfer shows it.
- R5: Status bit 1 (error) is also set when the function field is not 1 or the device field is not below NUM_OSC. Otherwise it is 0.
- R6: A successful command with bit 30 set (write) copies the outgoing data register into oscillator slot `device`.
- R7: A successful command with bit 30 clear (read) loads slot `device` into the return register. A failed read leaves the return register unchanged, and a failed write leaves every slot unchanged.
- R8: After synchronous reset the registers hold these values: control 0x00100000; status, outgoing data and return data 0; slot i holds OSC_INIT[32i+31:32i].
- R9: Bus writes to the return-data and status offsets have no effect.
- R10: `osc_values[32i+31:32i]` always shows oscillator slot i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase flag |
| pwrite | input | 1 | Write transfer when high |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| osc_values | output | 32*NUM_OSC | Flat view of the oscillator bank |

## Verification
A corrupted oscillator slot shows on `osc_values` one cycle after the faulty command. It also shows in the return register on the next read command of that slot. A wrong done or error decision, or a stale status, shows up in the first status read that follows the control write. Wrong masking of the control word shows up in the next control read-back. A clobbered return register shows up as soon as a failed read is followed by a read of 0xA0.

// File: rtl/osc_cfg_pkg.sv
package osc_cfg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DEV_W  = 12;
  localparam int unsigned FN_W   = 6;
  localparam int unsigned FN_LSB = 20;
  localparam int unsigned DIR_BIT = 30;
  localparam int unsigned GO_BIT  = 31;

  localparam logic [ADDR_W-1:0] OFF_RTN  = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFF_OUT  = 12'h0A4;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h0A8;
  localparam logic [ADDR_W-1:0] OFF_STAT = 12'h0AC;

  localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h43F0_0FFF;
  localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0010_0000;
  localparam logic [FN_W-1:0]   FN_OSC     = 6'd1;

  typedef enum logic [2:0] {
    SEL_RTN, SEL_OUT, SEL_CTRL, SEL_STAT, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_RTN:  return SEL_RTN;
      OFF_OUT:  return SEL_OUT;
      OFF_CTRL: return SEL_CTRL;
      OFF_STAT: return SEL_STAT;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/osc_cfg_bank.sv
module osc_cfg_bank
  import osc_cfg_pkg::*;
#(
  parameter int unsigned NUM_OSC = 3,
  parameter logic [NUM_OSC*DATA_W-1:0] OSC_INIT = '0,
  localparam int unsigned IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [IDX_W-1:0]          ridx,
  output logic [DATA_W-1:0]         rdata,
  output logic [NUM_OSC*DATA_W-1:0] flat
);
  logic [DATA_W-1:0] slot_q [NUM_OSC];

  for (genvar i = 0; i < NUM_OSC; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[i] <= OSC_INIT[i*DATA_W +: DATA_W];
      end else if (we && (widx == IDX_W'(i))) begin
        slot_q[i] <= wdata;
      end
    end
    assign flat[i*DATA_W +: DATA_W] = slot_q[i];
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_OSC; k++) begin
      if (ridx == IDX_W'(k)) rdata = slot_q[k];
    end
  end
endmodule

// File: rtl/osc_cfg_engine.sv
module osc_cfg_engine
  import osc_cfg_pkg::*;
#(
  parameter int unsigned NUM_OSC = 3,
  localparam int unsigned IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr,
  input  logic              out_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bank_rdata,
  output logic              bank_we,
  output logic [IDX_W-1:0]  bank_idx,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [1:0]        stat_q,
  output logic [DATA_W-1:0] rtn_q,
  output logic [DATA_W-1:0] out_q
);
  logic [DEV_W-1:0] dev;
  logic [FN_W-1:0]  fn;
  logic             go, dir_wr, accept;

  always_comb begin
    dev    = wdata[DEV_W-1:0];
    fn     = wdata[FN_LSB +: FN_W];
    go     = wdata[GO_BIT];
    dir_wr = wdata[DIR_BIT];
    accept = (fn == FN_OSC) && (dev < DEV_W'(NUM_OSC));
    bank_idx = accept ? dev[IDX_W-1:0] : '0;
    bank_we  = ctrl_wr && go && dir_wr && accept;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
      stat_q <= '0;
      rtn_q  <= '0;
      out_q  <= '0;
    end else begin
      if (out_wr) out_q <= wdata;
      if (ctrl_wr) begin
        ctrl_q <= wdata & CTRL_KEEP;
        stat_q <= go ? {~accept, 1'b1} : 2'b00;
        if (go && !dir_wr && accept) rtn_q <= bank_rdata;
      end
    end
  end
endmodule

// File: rtl/osc_cfg_port.sv
module osc_cfg_port
  import osc_cfg_pkg::*;
#(
  parameter int unsigned NUM_OSC = 3,
  parameter logic [NUM_OSC*DATA_W-1:0] OSC_INIT =
    {32'd50_000_000, 32'd24_576_000, 32'd25_000_000}
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      psel,
  input  logic                      penable,
  input  logic                      pwrite,
  input  logic [ADDR_W-1:0]         paddr,
  input  logic [DATA_W-1:0]         pwdata,
  output logic [DATA_W-1:0]         prdata,
  output logic [NUM_OSC*DATA_W-1:0] osc_values
);
  localparam int unsigned IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1;

  reg_sel_e          sel;
  logic              wr_access, rd_setup, ctrl_wr, out_wr, bank_we;
  logic [IDX_W-1:0]  bank_idx;
  logic [DATA_W-1:0] bank_rdata, ctrl_q, rtn_q, out_q, rd_mux;
  logic [1:0]        stat_q;

  assign sel       = decode_off(paddr);
  assign wr_access = psel && penable && pwrite;
  assign rd_setup  = psel && !penable && !pwrite;
  assign ctrl_wr   = wr_access && (sel == SEL_CTRL);
  assign out_wr    = wr_access && (sel == SEL_OUT);

  osc_cfg_engine #(.NUM_OSC(NUM_OSC)) u_engine (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .out_wr(out_wr),
    .wdata(pwdata), .bank_rdata(bank_rdata), .bank_we(bank_we),
    .bank_idx(bank_idx), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .rtn_q(rtn_q), .out_q(out_q)
  );

  osc_cfg_bank #(.NUM_OSC(NUM_OSC), .OSC_INIT(OSC_INIT)) u_bank (
    .clk(clk), .rst(rst), .we(bank_we), .widx(bank_idx),
    .wdata(out_q), .ridx(bank_idx), .rdata(bank_rdata),
    .flat(osc_values)
  );

  always_comb begin
    case (sel)
      SEL_RTN:  rd_mux = rtn_q;
      SEL_OUT:  rd_mux = out_q;
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_STAT: rd_mux = {30'd0, stat_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rd_mux;
  end
endmodule

// File: rtl/osc_cfg_port_chk.sv
module osc_cfg_port_chk
  import osc_cfg_pkg::*;
#(
  parameter int unsigned NUM_OSC = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      psel,
  input logic                      penable,
  input logic                      pwrite,
  input logic [ADDR_W-1:0]         paddr,
  input logic [DATA_W-1:0]         pwdata,
  input logic [DATA_W-1:0]         ctrl_q,
  input logic [1:0]                stat_q,
  input logic [DATA_W-1:0]         rtn_q,
  input logic [DATA_W-1:0]         out_q,
  input logic [NUM_OSC*DATA_W-1:0] osc_values
);
  localparam int unsigned IDX_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1;

  logic cw, go, ok;
  logic [IDX_W-1:0] idx_q;
  logic [DATA_W-1:0] slot_at_idx;

  assign cw = psel && penable && pwrite && (paddr == OFF_CTRL);
  assign go = pwdata[GO_BIT];
  assign ok = (pwdata[FN_LSB +: FN_W] == FN_OSC) &&
              (pwdata[DEV_W-1:0] < DEV_W'(NUM_OSC));

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= ok ? pwdata[IDX_W-1:0] : '0;
  end

  always_comb begin
    slot_at_idx = '0;
    for (int k = 0; k < NUM_OSC; k++) begin
      if (idx_q == IDX_W'(k)) slot_at_idx = osc_values[k*DATA_W +: DATA_W];
    end
  end

  AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (rst)
    cw |=> ctrl_q == ($past(pwdata) & CTRL_KEEP)); // R2
  AST_STAT_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (cw && !go) |=> stat_q == 2'b00); // R3
  AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
    (cw && go) |=> stat_q[0]); // R4
  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (rst)
    (cw && go) |=> stat_q[1] == !$past(ok)); // R5
  AST_OSC_LANDS: assert property (@(posedge clk) disable iff (rst)
    (cw && go && pwdata[DIR_BIT] && ok) |=> slot_at_idx == $past(out_q)); // R6
  AST_RTN_KEPT_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
    (cw && go && !pwdata[DIR_BIT] && !ok) |=> $stable(rtn_q)); // R7
  AST_STAT_ONLY_BY_CTRL: assert property (@(posedge clk) disable iff (rst)
    !cw |=> $stable(stat_q)); // R9
endmodule

bind osc_cfg_port osc_cfg_port_chk #(.NUM_OSC(NUM_OSC)) u_chk (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .ctrl_q(ctrl_q), .stat_q(stat_q),
  .rtn_q(rtn_q), .out_q(out_q), .osc_values(osc_values)
);

// File: tb/osc_cfg_port_tb.sv
module osc_cfg_port_tb;
  localparam int N = 3;
  localparam logic [31:0] INIT0 = 32'd25_000_000;
  localparam logic [31:0] INIT1 = 32'd24_576_000;
  localparam logic [31:0] INIT2 = 32'd50_000_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [N*32-1:0] osc_values;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [N];
  logic [31:0] rtn_model;

  always #4 clk = ~clk;

  osc_cfg_port u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .osc_values(osc_values)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < N; i++) check(tag, osc_values[i*32 +: 32], model[i]);
  endtask

  initial begin
    logic [31:0] v, pat, cmd;
    logic good;
    int fns [4] = '{0, 1, 2, 63};
    model[0] = INIT0; model[1] = INIT1; model[2] = INIT2;
    rtn_model = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8 reset state, R10 flat bus layout
    bus_rd(12'h0A8, v); check("R8 ctrl reset", v, 32'h0010_0000);
    bus_rd(12'h0AC, v); check("R8 status reset", v, 32'h0);
    bus_rd(12'h0A0, v); check("R8 rtn reset", v, 32'h0);
    bus_rd(12'h0A4, v); check("R8 out reset", v, 32'h0);
    check_bank("R8 R10 slot reset");

    // R1 unmapped offsets read zero, out register is read/write
    bus_rd(12'h000, v); check("R1 unmapped 0x000", v, 32'h0);
    bus_rd(12'h0B0, v); check("R1 unmapped 0x0B0", v, 32'h0);
    bus_wr(12'h0A4, 32'hDEAD_BEEF);
    bus_rd(12'h0A4, v); check("R1 out readback", v, 32'hDEAD_BEEF);

    // R2 masking, R3 no-start clears status
    bus_wr(12'h0A8, 32'h3FFF_FFFF);
    bus_rd(12'h0A8, v); check("R2 ctrl mask", v, 32'h03F0_0FFF);
    bus_rd(12'h0AC, v); check("R3 no-start status", v, 32'h0);

    // near-exhaustive command sweep: device 0..N+2, several function codes
    for (int d = 0; d < N + 3; d++) begin
      for (int f = 0; f < 4; f++) begin
        good = (fns[f] == 1) && (d < N);
        pat = 32'hA500_0000 ^ (32'(d) << 12) ^ 32'(fns[f] * 7 + 1);
        bus_wr(12'h0A4, pat);
        cmd = 32'h8000_0000 | 32'h4000_0000 | (32'(fns[f]) << 20) | 32'(d);
        bus_wr(12'h0A8, cmd);
        if (good) model[d] = pat;
        bus_rd(12'h0AC, v); check("R4 R5 write status", v, good ? 32'h1 : 32'h3);
        check_bank("R6 R7 slot after write cmd");
        bus_rd(12'h0A8, v); check("R2 ctrl after cmd", v, cmd & 32'h43F0_0FFF);
        cmd = 32'h8000_0000 | (32'(fns[f]) << 20) | 32'(d);
        bus_wr(12'h0A8, cmd);
        if (good) rtn_model = model[d];
        bus_rd(12'h0AC, v); check("R4 R5 read status", v, good ? 32'h1 : 32'h3);
        bus_rd(12'h0A0, v); check("R7 rtn after read cmd", v, rtn_model);
      end
    end

    // R3 status cleared by plain control write after an error
    bus_wr(12'h0A8, 32'h8000_0FFF);
    bus_rd(12'h0AC, v); check("R5 huge device", v, 32'h3);
    bus_wr(12'h0A8, 32'h0010_0001);
    bus_rd(12'h0AC, v); check("R3 clear after error", v, 32'h0);

    // R9 writes to return and status offsets ignored
    bus_wr(12'h0A8, 32'h8010_0002);
    rtn_model = model[2];
    bus_wr(12'h0A0, 32'h1234_5678);
    bus_wr(12'h0AC, 32'h0000_0000);
    bus_rd(12'h0A0, v); check("R9 rtn write ignored", v, rtn_model);
    bus_rd(12'h0AC, v); check("R9 status write ignored", v, 32'h1);
    check_bank("R9 R10 bank untouched");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule